// File: doc/BRIEF.md
# Card Clock Generator with Divider and Bypass

This block derives the clock sent to a memory card from the master clock of the host controller. Software programs a single configuration word. The word holds a divide value N, an enable bit, a power-save bit, a bypass bit and two bus-width flags. With bypass clear, the block counts master cycles and toggles the card clock every N+1 cycles. The result is a square wave of master/(2·(N+1)) with equal high and low phases. With bypass set, the master clock is passed straight out.

Next to the clock, the block gives the command and data engines a one-cycle strobe on every rising card-clock edge. It also reports how many data lines the configured bus width uses. A power-save mode stops the card clock whenever the controller signals that the bus is idle. A changed divide value is only picked up when the counter reloads, so a half phase that has already started always runs to its full length.

Top module: `cardclk_gen`

## Requirements
- R1: With enable set, bypass clear and power-save inactive, the card clock has high and low phases of exactly N+1 master cycles each, so its period is 2·(N+1) cycles. N is the unsigned value of configuration bits [DIV_W-1:0].
- R2: With enable (bit DIV_W) and bypass (bit DIV_W+2) both set, the card clock follows the master clock: high while the master clock is high and low while it is low. The divide field has no effect on it.
- R3: With the enable bit clear, the card clock stays low and the strobe stays low. Writing an all-zero word stops a running clock within two master cycles.
- R4: With power-save (bit DIV_W+1) and enable set, the card clock is held low while bus_busy is low and runs as in R1 while bus_busy is high.
- R5: card_rise_stb is high for exactly the first master cycle of each card-clock high phase and low in every other cycle. In bypass it is high in every cycle.
- R6: bus_mode is 2 (eight lines) when bit DIV_W+4 is set, 1 (four lines) when only bit DIV_W+3 is set, and 0 (one line) when neither is set. The eight-line flag wins when both are set. The new mode shows one cycle after the write.
- R7: A new divide value written while the clock runs takes effect at the next toggle. The half phase in progress completes with the old length, and the following phase uses the new one.
- R8: After reset, card_clk, card_rise_stb and bus_mode are all 0.
- R9: The largest divide value (all ones) gives the slowest clock, with a period of 2^(DIV_W+1) master cycles, which is 512 at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | DIV_W+5 | Configuration word: divide, enable, power-save, bypass, 4-line, 8-line (low to high) |
| bus_busy | input | 1 | High while a command or data transfer uses the bus |
| card_clk | output | 1 | Card clock |
| card_rise_stb | output | 1 | One-cycle strobe on each rising card-clock edge |
| bus_mode | output | 2 | Data-line mode: 0 one line, 1 four lines, 2 eight lines |

## Verification
The bench builds the block with DIV_W = 4. This makes the divide range small enough to sweep all sixteen values, including the slowest setting, and to measure both phase lengths and the strobe position for each one. The narrow width also keeps divide changes in mid-run, bypass, power-save gating and every combination of the bus-width flags within a short run. The expected phase lengths are computed as N+1 in the bench.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef enum logic [1:0] {
        BUS_1LINE = 2'd0,
        BUS_4LINE = 2'd1,
        BUS_8LINE = 2'd2
    } bus_mode_e;

    // Field offsets above the divide field
    localparam int OFS_EN    = 0;
    localparam int OFS_PSAVE = 1;
    localparam int OFS_BYP   = 2;
    localparam int OFS_W4    = 3;
    localparam int OFS_W8    = 4;
    localparam int CTRL_BITS = 5;

endpackage

// File: rtl/cardclk_cfg_reg.sv
module cardclk_cfg_reg
    import cardclk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CFG_W = DIV_W + CTRL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [DIV_W-1:0] div_val,
    output logic             en,
    output logic             psave,
    output logic             byp,
    output logic [1:0]       mode
);

    typedef struct packed {
        logic             w8;
        logic             w4;
        logic             byp;
        logic             psave;
        logic             en;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    bus_mode_e mode_dec;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        if (cfg_q.w8) begin
            mode_dec = BUS_8LINE;
        end else if (cfg_q.w4) begin
            mode_dec = BUS_4LINE;
        end else begin
            mode_dec = BUS_1LINE;
        end
    end

    assign div_val = cfg_q.div;
    assign en      = cfg_q.en;
    assign psave   = cfg_q.psave;
    assign byp     = cfg_q.byp;
    assign mode    = mode_dec;

endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_clk,
    output logic             rise_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] nact;
        logic             clk_o;
        logic             stb;
    } dstate_t;

    dstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!run) begin
            st_d.cnt   = '0;
            st_d.clk_o = 1'b0;
            st_d.nact  = div_val;
        end else if (st_q.cnt == st_q.nact) begin
            // end of a half phase: toggle and pick up the latest divide value
            st_d.cnt   = '0;
            st_d.clk_o = ~st_q.clk_o;
            st_d.stb   = ~st_q.clk_o;
            st_d.nact  = div_val;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk  = st_q.clk_o;
    assign rise_stb = st_q.stb;

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CFG_W = DIV_W + CTRL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             bus_busy,
    output logic             card_clk,
    output logic             card_rise_stb,
    output logic [1:0]       bus_mode
);

    typedef struct packed {
        logic gate;
        logic byp;
    } gstate_t;

    logic [DIV_W-1:0] cfg_div;
    logic             cfg_en;
    logic             cfg_psave;
    logic             cfg_byp;
    logic             div_run;
    logic             pass_q;
    logic             div_clk;
    logic             div_stb;
    gstate_t          g_d, g_q;

    cardclk_cfg_reg #(
        .DIV_W (DIV_W),
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .div_val (cfg_div),
        .en      (cfg_en),
        .psave   (cfg_psave),
        .byp     (cfg_byp),
        .mode    (bus_mode)
    );

    // Registered gate: enable, minus idle periods when power-save is on
    always_comb begin
        g_d      = g_q;
        g_d.gate = cfg_en & ~(cfg_psave & ~bus_busy);
        g_d.byp  = cfg_byp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign div_run = g_q.gate & ~g_q.byp;
    assign pass_q  = g_q.gate & g_q.byp;

    cardclk_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (div_run),
        .div_val  (cfg_div),
        .div_clk  (div_clk),
        .rise_stb (div_stb)
    );

    assign card_clk      = pass_q ? clk : div_clk;
    assign card_rise_stb = pass_q | div_stb;

endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_q,
    input logic       gate_q,
    input logic       byp_q,
    input logic       div_run,
    input logic       div_clk,
    input logic       div_stb,
    input logic       card_rise_stb,
    input logic [1:0] bus_mode
);

    assert_stb_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_stb |-> (div_clk && !$past(div_clk)));

    assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_q) && !$past(en_q, 2)) |-> (!card_rise_stb && !div_clk));

    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode != 2'b11);

    assert_divider_idle_in_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_q && byp_q) |-> !div_clk);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(div_run) |-> (!div_clk && !div_stb));

endmodule

bind cardclk_gen cardclk_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_q          (cfg_en),
    .gate_q        (g_q.gate),
    .byp_q         (g_q.byp),
    .div_run       (div_run),
    .div_clk       (div_clk),
    .div_stb       (div_stb),
    .card_rise_stb (card_rise_stb),
    .bus_mode      (bus_mode)
);

// File: tb/cardclk_gen_tb_top.sv
`timescale 1ns/1ps
module cardclk_gen_tb_top;

    localparam int DW    = 4;
    localparam int CW    = DW + 5;
    localparam int B_EN  = DW;
    localparam int B_PS  = DW + 1;
    localparam int B_BYP = DW + 2;
    localparam int B_W4  = DW + 3;
    localparam int B_W8  = DW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          bus_busy = 1'b0;
    logic          card_clk;
    logic          card_rise_stb;
    logic [1:0]    bus_mode;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    cardclk_gen #(.DIV_W(DW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .bus_busy      (bus_busy),
        .card_clk      (card_clk),
        .card_rise_stb (card_rise_stb),
        .bus_mode      (bus_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                summary();
            end
        end
    end

    function automatic logic [CW-1:0] word(input int n, input bit en, input bit ps,
                                           input bit byp, input bit w4, input bit w8);
        logic [CW-1:0] w;
        w        = '0;
        w[DW-1:0] = n[DW-1:0];
        w[B_EN]  = en;
        w[B_PS]  = ps;
        w[B_BYP] = byp;
        w[B_W4]  = w4;
        w[B_W8]  = w8;
        return w;
    endfunction

    task automatic wr(input logic [CW-1:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Wait at negedges for a low-to-high transition of card_clk
    task automatic wait_rise(input string req, output bit found);
        bit prev;
        found = 1'b0;
        @(negedge clk);
        prev = card_clk;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (card_clk && !prev) begin
                found = 1'b1;
                break;
            end
            prev = card_clk;
        end
        check(found, req, 0, 1);
    endtask

    // Measure one full period starting at a rise; R1, R5, R9
    task automatic measure(input int n, input string req);
        bit found;
        int hi, lo, extra_stb;
        wait_rise(req, found);
        if (found) begin
            check(card_rise_stb == 1'b1, "R5 strobe at rise", card_rise_stb, 1);
            hi = 1; lo = 0; extra_stb = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!card_clk) break;
                hi++;
                if (card_rise_stb) extra_stb++;
            end
            for (int i = 0; i < 100; i++) begin
                if (card_clk) break;
                lo++;
                if (card_rise_stb) extra_stb++;
                @(negedge clk);
            end
            check(hi == n + 1, {req, " high phase"}, hi, n + 1);
            check(lo == n + 1, {req, " low phase"}, lo, n + 1);
            check(extra_stb == 0, "R5 strobe outside rise", extra_stb, 0);
            check(card_rise_stb == 1'b1, "R5 strobe at next rise", card_rise_stb, 1);
        end
    endtask

    initial begin
        bit found;
        int cnt;

        // R8: reset state
        #3;
        check(card_clk == 1'b0, "R8 card_clk", card_clk, 0);
        check(card_rise_stb == 1'b0, "R8 strobe", card_rise_stb, 0);
        check(bus_mode == 2'd0, "R8 bus_mode", bus_mode, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(card_clk == 1'b0 && card_rise_stb == 1'b0, "R8 after release", card_clk, 0);

        // R3: divide value set but enable clear
        wr(word(2, 0, 0, 0, 0, 0));
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (card_clk || card_rise_stb) cnt++;
        end
        check(cnt == 0, "R3 disabled stays low", cnt, 0);

        // R1 / R9: sweep every divide value, largest last
        for (int n = 0; n < (1 << DW); n++) begin
            wr('0);
            wr(word(n, 1, 0, 0, 0, 0));
            measure(n, (n == (1 << DW) - 1) ? "R9 slowest" : "R1 divide");
        end

        // R7: change divide from 3 to 6 during a high phase
        wr('0);
        wr(word(3, 1, 0, 0, 0, 0));
        wait_rise("R7 rise", found);
        if (found) begin
            int hi, lo, hi2;
            cfg_we    = 1'b1;
            cfg_wdata = word(6, 1, 0, 0, 0, 0);
            @(negedge clk);
            cfg_we = 1'b0;
            hi = 1; lo = 0; hi2 = 0;
            for (int i = 0; i < 100; i++) begin
                if (!card_clk) break;
                hi++;
                @(negedge clk);
            end
            for (int i = 0; i < 100; i++) begin
                if (card_clk) break;
                lo++;
                @(negedge clk);
            end
            for (int i = 0; i < 100; i++) begin
                if (!card_clk) break;
                hi2++;
                @(negedge clk);
            end
            check(hi == 4, "R7 old phase completes", hi, 4);
            check(lo == 7, "R7 new low phase", lo, 7);
            check(hi2 == 7, "R7 new high phase", hi2, 7);
        end

        // R3: all-zero write stops a running clock
        wr(word(1, 1, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        wr('0);
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (card_clk || card_rise_stb) cnt++;
        end
        check(cnt == 0, "R3 zero write stops", cnt, 0);

        // R2 / R5: bypass with a divide value present
        wr(word(5, 1, 0, 1, 0, 0));
        repeat (3) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #2;
            if (card_clk !== 1'b1 || card_rise_stb !== 1'b1) cnt++;
            @(negedge clk); #2;
            if (card_clk !== 1'b0 || card_rise_stb !== 1'b1) cnt++;
        end
        check(cnt == 0, "R2 bypass follows master / R5 strobe every cycle", cnt, 0);

        // R3: bypass with enable clear
        wr(word(5, 0, 0, 1, 0, 0));
        repeat (2) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #2;
            if (card_clk || card_rise_stb) cnt++;
        end
        check(cnt == 0, "R3 bypass disabled", cnt, 0);

        // R4: power-save with idle bus, then busy bus
        bus_busy = 1'b0;
        wr(word(2, 1, 1, 0, 0, 0));
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (card_clk || card_rise_stb) cnt++;
        end
        check(cnt == 0, "R4 idle holds clock", cnt, 0);
        bus_busy = 1'b1;
        measure(2, "R4 busy runs");
        bus_busy = 1'b0;
        repeat (2) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (card_clk) cnt++;
        end
        check(cnt == 0, "R4 idle again stops", cnt, 0);

        // R6: bus width decode for every flag combination
        for (int m = 0; m < 4; m++) begin
            int exp_mode;
            exp_mode = (m & 2) ? 2 : ((m & 1) ? 1 : 0);
            wr(word(0, 0, 0, 0, m[0], m[1]));
            check(int'(bus_mode) == exp_mode, "R6 bus_mode", bus_mode, exp_mode);
        end

        summary();
    end

endmodule